// File: doc/BRIEF.md
# I2C Acknowledge Sequencer

This block handles the acknowledge slot of an I2C serial engine. It finds rising and falling edges on the synchronized SCL level and counts the rising edges of each byte. From these it opens an acknowledge window on the falling edge that ends the eighth data bit. It closes the window on the ninth rising edge. A start condition restarts the count at any point.

When the engine is receiving, the block decides whether to pull SDA low (ACK) or leave it released (NACK) for the ninth bit. It makes that choice when the window opens.
- On an address byte that matched, the general acknowledge control sets the answer.
- Otherwise a zero remaining-byte count selects the last-byte control.
- Any other count selects the general acknowledge control.
- A bus error always forces a release.

When the engine is transmitting, the block never drives SDA. Instead it captures the receiver's answer into a status flag on the ninth rising edge.

Top module: `i2c_ack_sequencer`

## Requirements
- R1: After synchronous reset, `ack_window`, `sda_pull_low` and `nack_seen` are all 0.
- R2: `ack_window` rises one clock after the SCL falling edge that follows the 8th rising SCL edge of a byte. It stays low before that edge.
- R3: `ack_window` and `sda_pull_low` fall one clock after the 9th rising SCL edge. The count then restarts, so the next byte opens its window at the same bit position.
- R4: A `start_seen` pulse restarts the bit count and clears `ack_window` and `sda_pull_low` on the next clock.
- R5: Receiving, with `addr_hit`=0 and `bytes_left` nonzero: `sda_pull_low` becomes 1 with the window when `ack_ctl`=0 (ACK). It stays 0 when `ack_ctl`=1 (NACK).
- R6: Receiving, with `addr_hit`=0 and `bytes_left`=0: `last_ack_ctl` picks the answer. A value of 0 pulls SDA low and 1 releases it. `ack_ctl` has no effect.
- R7: Receiving, with `addr_hit`=1: `ack_ctl` picks the answer whatever `bytes_left` holds.
- R8: While `bus_fault` is 1, `sda_pull_low` is 0 from the next clock onward. This holds both when the window opens and when the fault arrives inside an open window.
- R9: Transmitting (`rx_dir`=0): `sda_pull_low` stays 0. On the 9th rising SCL edge, `nack_seen` takes the SDA level (1 = no ACK received, 0 = ACK received). It is visible one clock later.
- R10: `nack_seen` keeps its value through receive bytes and between acknowledge slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_lvl | input | 1 | Synchronized SCL level |
| sda_lvl | input | 1 | Synchronized SDA level |
| start_seen | input | 1 | One-cycle pulse on a start condition |
| rx_dir | input | 1 | 1 = engine receives and answers, 0 = engine transmits |
| bytes_left | input | CNT_W | Remaining-byte count |
| addr_hit | input | 1 | Current byte is a matching address |
| bus_fault | input | 1 | Bus error present |
| ack_ctl | input | 1 | General acknowledge control (1 = NACK) |
| last_ack_ctl | input | 1 | Acknowledge control when the count is zero (1 = NACK) |
| ack_window | output | 1 | Acknowledge window status |
| sda_pull_low | output | 1 | Request to pull SDA low |
| nack_seen | output | 1 | Last transmitted byte was not acknowledged |

## Verification
Every result is registered once behind the edge detector. The output therefore changes on the first clock after an SCL, start or fault input changes. The bench drives inputs on the falling clock edge and samples exactly one clock later, on the next falling edge. Window checks are placed at that point: just after the 8th falling SCL edge, and again just after the 9th rising SCL edge. Each check also reads the window one sample earlier, to show it has not opened early.

// File: rtl/i2c_ack_pkg.sv
package i2c_ack_pkg;
  // returns 1 when the acknowledge slot must be released (NACK)
  function automatic logic pick_nack(
    input logic addr_hit,
    input logic count_zero,
    input logic ack_ctl,
    input logic last_ack_ctl,
    input logic bus_fault
  );
    logic sel;
    if (addr_hit)        sel = ack_ctl;
    else if (count_zero) sel = last_ack_ctl;
    else                 sel = ack_ctl;
    return sel | bus_fault;
  endfunction
endpackage

// File: rtl/ack_bit_counter.sv
module ack_bit_counter #(
  parameter int BITS = 8,
  localparam int BCW = $clog2(BITS + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           scl_lvl,
  input  logic           start_seen,
  output logic           scl_rise,
  output logic           scl_fall,
  output logic           at_last,
  output logic [BCW-1:0] bit_cnt
);
  logic scl_q;

  always_ff @(posedge clk) begin
    if (rst) scl_q <= 1'b1;
    else     scl_q <= scl_lvl;
  end

  assign scl_rise = scl_lvl & ~scl_q;
  assign scl_fall = ~scl_lvl & scl_q;
  assign at_last  = (bit_cnt == BCW'(BITS));

  always_ff @(posedge clk) begin
    if (rst || start_seen)  bit_cnt <= '0;
    else if (scl_rise) begin
      if (at_last) bit_cnt <= '0;
      else         bit_cnt <= bit_cnt + 1'b1;
    end
  end

  // R2: count never passes the last data bit
  a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= BCW'(BITS));
  // R4: start restarts the count
  a_r4_start_clears: assert property (@(posedge clk) disable iff (rst)
    start_seen |=> bit_cnt == '0);
endmodule

// File: rtl/ack_decider.sv
module ack_decider #(
  parameter int CNT_W = 8
) (
  input  logic             rx_dir,
  input  logic [CNT_W-1:0] bytes_left,
  input  logic             addr_hit,
  input  logic             bus_fault,
  input  logic             ack_ctl,
  input  logic             last_ack_ctl,
  output logic             want_pull
);
  import i2c_ack_pkg::*;
  logic nack;

  always_comb begin
    nack      = pick_nack(addr_hit, bytes_left == '0, ack_ctl, last_ack_ctl, bus_fault);
    want_pull = rx_dir & ~nack;
  end
endmodule

// File: rtl/i2c_ack_sequencer.sv
module i2c_ack_sequencer #(
  parameter int CNT_W = 8,
  parameter int BITS  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_lvl,
  input  logic             sda_lvl,
  input  logic             start_seen,
  input  logic             rx_dir,
  input  logic [CNT_W-1:0] bytes_left,
  input  logic             addr_hit,
  input  logic             bus_fault,
  input  logic             ack_ctl,
  input  logic             last_ack_ctl,
  output logic             ack_window,
  output logic             sda_pull_low,
  output logic             nack_seen
);
  localparam int BCW = $clog2(BITS + 1);

  logic           scl_rise, scl_fall, at_last, want_pull;
  logic [BCW-1:0] bit_cnt;
  logic           open_now, close_now;

  ack_bit_counter #(.BITS(BITS)) u_cnt (
    .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .start_seen(start_seen),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .at_last(at_last), .bit_cnt(bit_cnt)
  );

  ack_decider #(.CNT_W(CNT_W)) u_dec (
    .rx_dir(rx_dir), .bytes_left(bytes_left), .addr_hit(addr_hit),
    .bus_fault(bus_fault), .ack_ctl(ack_ctl), .last_ack_ctl(last_ack_ctl),
    .want_pull(want_pull)
  );

  assign open_now  = scl_fall & at_last;
  assign close_now = scl_rise & at_last;

  always_ff @(posedge clk) begin
    if (rst || start_seen) ack_window <= 1'b0;
    else if (open_now)     ack_window <= 1'b1;
    else if (close_now)    ack_window <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || start_seen || bus_fault) sda_pull_low <= 1'b0;
    else if (open_now)                  sda_pull_low <= want_pull;
    else if (close_now)                 sda_pull_low <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                                      nack_seen <= 1'b0;
    else if (close_now && !rx_dir && !start_seen) nack_seen <= sda_lvl;
  end

  // R5: SDA is only pulled inside the acknowledge window
  a_r5_pull_in_window: assert property (@(posedge clk) disable iff (rst)
    sda_pull_low |-> ack_window);
  // R8: a bus fault releases SDA on the next clock
  a_r8_fault_release: assert property (@(posedge clk) disable iff (rst)
    bus_fault |=> !sda_pull_low);
  // R9: a pull starts only while receiving
  a_r9_pull_rx_only: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_low) |-> $past(rx_dir));
  // R10: the status moves only at the close of a window
  a_r10_status_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(nack_seen) |-> $past(ack_window));
  // R3: the window opens only on a falling SCL edge
  a_r3_open_on_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_window) |-> $past(scl_fall));
endmodule

// File: tb/test_i2c_ack_sequencer.sv
module test_i2c_ack_sequencer;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, sda = 1'b1, start = 1'b0, rx = 1'b1;
  logic [CNT_W-1:0] left = '0;
  logic ahit = 1'b0, fault = 1'b0, actl = 1'b0, lctl = 1'b0;
  logic win, pull, nack;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  i2c_ack_sequencer #(.CNT_W(CNT_W), .BITS(8)) i_i2c_ack_sequencer (
    .clk(clk), .rst(rst), .scl_lvl(scl), .sda_lvl(sda), .start_seen(start),
    .rx_dir(rx), .bytes_left(left), .addr_hit(ahit), .bus_fault(fault),
    .ack_ctl(actl), .last_ack_ctl(lctl),
    .ack_window(win), .sda_pull_low(pull), .nack_seen(nack)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) begin
      scl = 1'b1; tick(2); scl = 1'b0; tick(2);
    end
  endtask

  // eight data bits, then stop one clock after the 8th falling edge
  task automatic to_window(input string req);
    pulses(7);
    scl = 1'b1; tick(2);
    chk({req, " window closed before 8th fall"}, win, 1'b0);
    scl = 1'b0; tick(1);
    chk({req, " window open"}, win, 1'b1);
  endtask

  // 9th clock with given SDA level, sampled one clock after the rise
  task automatic finish_byte(input logic sda_v, input string req);
    tick(1);
    sda = sda_v; scl = 1'b1; tick(1);
    chk({req, " window closed at 9th rise"}, win, 1'b0);
    chk({req, " pull released at 9th rise"}, pull, 1'b0);
    tick(1); scl = 1'b0; tick(2); sda = 1'b1;
  endtask

  task automatic rx_byte(input logic [CNT_W-1:0] l, input logic a, input logic ac,
                         input logic lc, input logic exp_pull, input string req);
    rx = 1'b1; left = l; ahit = a; actl = ac; lctl = lc;
    to_window(req);
    chk({req, " pull value"}, pull, exp_pull);
    finish_byte(1'b0, req);
  endtask

  task automatic t_reset;
    chk("R1 window", win, 1'b0);
    chk("R1 pull", pull, 1'b0);
    chk("R1 nack", nack, 1'b0);
  endtask

  task automatic t_start;
    pulses(3);
    start = 1'b1; tick(1); start = 1'b0;
    rx_byte(8'd5, 1'b0, 1'b0, 1'b1, 1'b1, "R4 after restart");
    rx = 1'b1; left = 8'd5; actl = 1'b0;
    to_window("R4");
    start = 1'b1; tick(1); start = 1'b0;
    chk("R4 window cleared", win, 1'b0);
    chk("R4 pull cleared", pull, 1'b0);
    tick(1); scl = 1'b1; tick(2); scl = 1'b0; tick(2);
    start = 1'b1; tick(1); start = 1'b0;
  endtask

  task automatic t_fault;
    rx = 1'b1; left = 8'd3; ahit = 1'b0; actl = 1'b0; fault = 1'b1;
    to_window("R8 fault at open");
    chk("R8 fault at open pull", pull, 1'b0);
    fault = 1'b0;
    finish_byte(1'b0, "R8");
    to_window("R8 fault in window");
    chk("R8 pull before fault", pull, 1'b1);
    fault = 1'b1; tick(1); fault = 1'b0;
    chk("R8 pull released", pull, 1'b0);
    chk("R8 window stays", win, 1'b1);
    finish_byte(1'b0, "R8");
  endtask

  task automatic t_tx;
    rx = 1'b0; left = 8'd2;
    to_window("R9 nack");
    chk("R9 no pull tx", pull, 1'b0);
    finish_byte(1'b1, "R9 nack");
    chk("R9 status nack", nack, 1'b1);
    // R10: receive bytes leave the status alone
    rx_byte(8'd4, 1'b0, 1'b0, 1'b0, 1'b1, "R10 rx");
    chk("R10 status held", nack, 1'b1);
    rx = 1'b0;
    to_window("R9 ack");
    finish_byte(1'b0, "R9 ack");
    chk("R9 status ack", nack, 1'b0);
  endtask

  initial begin : watchdog
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3); rst = 1'b0; tick(1);
    t_reset();
    scl = 1'b0; tick(2);
    rx_byte(8'd9, 1'b0, 1'b0, 1'b1, 1'b1, "R2 R5 ack");
    rx_byte(8'd9, 1'b0, 1'b1, 1'b0, 1'b0, "R3 R5 nack");
    rx_byte(8'd0, 1'b0, 1'b1, 1'b0, 1'b1, "R6 ack");
    rx_byte(8'd0, 1'b0, 1'b0, 1'b1, 1'b0, "R6 nack");
    rx_byte(8'd0, 1'b1, 1'b0, 1'b1, 1'b1, "R7 ack");
    rx_byte(8'd0, 1'b1, 1'b1, 1'b0, 1'b0, "R7 nack");
    t_start();
    t_fault();
    t_tx();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule